// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between a byte-wide host write bus and the program/erase controller of an 8-bit NOR-style flash array. Each clock it may receive one sampled bus write, made up of a strobe, a 20-bit address and a data byte. It follows the multi-write instruction protocol: a two-write unlock prefix, then a set-up command, and for erase a second unlock prefix and a confirm byte. When an instruction is complete, it raises a single-cycle request toward the controller. The requests are read-array, signature (auto-select), program with target address and byte, block erase with block address, chip erase, erase suspend and erase resume.

The sequencer also keeps the read mode that the host read path uses to pick its data source: the array, the signature bytes or the status byte. It drives the signature byte for the two low read address bits. It knows which operation is running from its own requests and from a completion pulse sent back by the controller. While an operation runs, it filters the host writes so that only the commands legal in that phase reach the controller. Any write that breaks an instruction sequence sends it back to read-array mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `read_mode` is 0 (array) and no request output is high.
- R2: An unlock prefix is byte AAh written where address bits 10:0 equal 555h, followed by byte 55h written where bits 10:0 equal 2AAh. Address bits 19:11 are ignored in these writes. `read_mode` encodes 0 = array, 1 = signature, 2 = status.
- R3: After an unlock prefix, a write of 90h at 555h pulses `req_auto_sel` and sets `read_mode` to 1. In that mode `sig_byte` is 20h for `sig_addr` = 00 and the device code (default D2h) for `sig_addr` = 01 (bit 0 is address bit 0). For other `sig_addr` values, and in any other mode, `sig_byte` is 00h.
- R4: After an unlock prefix, a write of A0h at 555h arms program. The next write, at any address and with any byte, pulses `req_program` with that address and byte on `req_addr`/`req_data`, and sets `read_mode` to 2.
- R5: Unlock, 80h at 555h, unlock, then 30h at any address pulses `req_blk_erase` with that address on `req_addr`, and sets `read_mode` to 2.
- R6: Unlock, 80h at 555h, unlock, then 10h at 555h pulses `req_chip_erase` and sets `read_mode` to 2.
- R7: When no operation is running, a write that does not fit the expected step aborts the instruction. No request is issued, `read_mode` becomes 0, and the next write is decoded as a new instruction.
- R8: F0h, written alone or directly after an unlock prefix, pulses `req_read_array` and sets `read_mode` to 0. During a running erase it also ends the erase.
- R9: B0h, written at any address without an unlock prefix, pulses `req_suspend` and sets `read_mode` to 0, but only while a block erase is running. It has no effect when idle or during a chip erase.
- R10: While an erase is suspended, 30h at any address pulses `req_resume` and sets `read_mode` to 2. A full program instruction is also accepted. All other writes issue nothing and leave `read_mode` unchanged.
- R11: While a program or erase runs, writes other than those in R8 and R9 are ignored. A `ctl_done` pulse ends the running operation, and a suspended program returns to the suspended state.
- R12: Each request is a one-cycle pulse in the cycle after the write that completes it. At most one request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | One sampled host write this cycle |
| wr_addr | input | 20 | Latched write address |
| wr_data | input | 8 | Latched write byte |
| ctl_done | input | 1 | Controller pulse: running operation finished |
| sig_addr | input | 2 | Read address bits 1:0 for signature selection |
| req_read_array | output | 1 | Read-array request pulse |
| req_auto_sel | output | 1 | Signature mode request pulse |
| req_program | output | 1 | Program request pulse |
| req_blk_erase | output | 1 | Block erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_addr | output | 20 | Address for program or block erase |
| req_data | output | 8 | Byte to program |
| read_mode | output | 2 | 0 array, 1 signature, 2 status |
| sig_byte | output | 8 | Signature byte for sig_addr |

## Verification
The hardest state to reach is a program that runs inside a suspended block erase. To get there, the stimulus runs a full six-write block erase and then suspends it. It enters a full unlock-and-program instruction and sends a completion pulse. Only then does it resume, to show that the sequencer went back to suspended rather than to idle. The same run probes the filters. B0h is sent while idle and during a chip erase, a full signature instruction is sent while a program is busy, and these stray commands must raise no request at all.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_SIG    = 2'd1,
        RM_STATUS = 2'd2
    } rmode_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_UNL1,
        CS_UNL2,
        CS_PROG_ARM,
        CS_ERS_U0,
        CS_ERS_U1,
        CS_ERS_CF
    } cstep_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE,
        OP_SUSP,
        OP_SUSP_PROG
    } op_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_SIG     = 8'h90;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERS_SET = 8'h80;
    localparam logic [7:0] CMD_BLK_CF  = 8'h30;
    localparam logic [7:0] CMD_CHIP_CF = 8'h10;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;

    localparam int RQ_RD   = 0;
    localparam int RQ_SIG  = 1;
    localparam int RQ_PROG = 2;
    localparam int RQ_BLK  = 3;
    localparam int RQ_CHIP = 4;
    localparam int RQ_SUSP = 5;
    localparam int RQ_RES  = 6;
    localparam int RQ_N    = 7;

endpackage

// File: rtl/flash_key_match.sv
module flash_key_match #(
    parameter int              CHK_W  = 11,
    parameter logic [CHK_W-1:0] KEY_A = 'h555,
    parameter logic [CHK_W-1:0] KEY_B = 'h2AA
) (
    input  logic [CHK_W-1:0] addr_lo,
    output logic             hit_a,
    output logic             hit_b
);
    assign hit_a = (addr_lo == KEY_A);
    assign hit_b = (addr_lo == KEY_B);
endmodule

// File: rtl/flash_sig_mux.sv
module flash_sig_mux #(
    parameter int               DATA_W   = 8,
    parameter logic [DATA_W-1:0] MFR_CODE = 'h20,
    parameter logic [DATA_W-1:0] DEV_CODE = 'hD2
) (
    input  logic              sig_on,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] byte_o
);
    always_comb begin
        byte_o = '0;
        if (sig_on) begin
            case (sel)
                2'b00:   byte_o = MFR_CODE;
                2'b01:   byte_o = DEV_CODE;
                default: byte_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int               ADDR_W   = 20,
    parameter int               DATA_W   = 8,
    parameter int               CHK_W    = 11,
    parameter logic [DATA_W-1:0] MFR_CODE = 'h20,
    parameter logic [DATA_W-1:0] DEV_CODE = 'hD2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctl_done,
    input  logic [1:0]        sig_addr,
    output logic              req_read_array,
    output logic              req_auto_sel,
    output logic              req_program,
    output logic              req_blk_erase,
    output logic              req_chip_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [1:0]        read_mode,
    output logic [DATA_W-1:0] sig_byte
);
    typedef struct packed {
        op_e               op;
        cstep_e            step;
        rmode_e            mode;
        logic              blk;
        logic [RQ_N-1:0]   req;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;
    logic hit_a, hit_b;
    logic busy;

    flash_key_match #(.CHK_W(CHK_W)) u_match (
        .addr_lo (wr_addr[CHK_W-1:0]),
        .hit_a   (hit_a),
        .hit_b   (hit_b)
    );

    flash_sig_mux #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_sig (
        .sig_on (s_q.mode == RM_SIG),
        .sel    (sig_addr),
        .byte_o (sig_byte)
    );

    assign busy = (s_q.op == OP_PROG) || (s_q.op == OP_ERASE) || (s_q.op == OP_SUSP_PROG);

    always_comb begin
        s_d     = s_q;
        s_d.req = '0;
        if (ctl_done && busy) begin
            // completion wins over a write in the same cycle
            s_d.op   = (s_q.op == OP_SUSP_PROG) ? OP_SUSP : OP_NONE;
            s_d.step = CS_IDLE;
        end else if (wr_en) begin
            case (s_q.op)
                OP_NONE: begin
                    s_d.step = CS_IDLE;
                    if (s_q.step == CS_PROG_ARM) begin
                        s_d.req[RQ_PROG] = 1'b1;
                        s_d.addr = wr_addr;
                        s_d.data = wr_data;
                        s_d.op   = OP_PROG;
                        s_d.mode = RM_STATUS;
                    end else if (wr_data == CMD_RESET && (s_q.step == CS_IDLE || s_q.step == CS_UNL2)) begin
                        s_d.req[RQ_RD] = 1'b1;
                        s_d.mode = RM_ARRAY;
                    end else begin
                        s_d.mode = RM_ARRAY;   // abort unless a legal step follows
                        case (s_q.step)
                            CS_IDLE: if (wr_data == CMD_KEY_A && hit_a) begin
                                s_d.step = CS_UNL1; s_d.mode = s_q.mode;
                            end
                            CS_UNL1: if (wr_data == CMD_KEY_B && hit_b) begin
                                s_d.step = CS_UNL2; s_d.mode = s_q.mode;
                            end
                            CS_UNL2: begin
                                if (hit_a && wr_data == CMD_SIG) begin
                                    s_d.req[RQ_SIG] = 1'b1;
                                    s_d.mode = RM_SIG;
                                end else if (hit_a && wr_data == CMD_PROG) begin
                                    s_d.step = CS_PROG_ARM; s_d.mode = s_q.mode;
                                end else if (hit_a && wr_data == CMD_ERS_SET) begin
                                    s_d.step = CS_ERS_U0; s_d.mode = s_q.mode;
                                end
                            end
                            CS_ERS_U0: if (wr_data == CMD_KEY_A && hit_a) begin
                                s_d.step = CS_ERS_U1; s_d.mode = s_q.mode;
                            end
                            CS_ERS_U1: if (wr_data == CMD_KEY_B && hit_b) begin
                                s_d.step = CS_ERS_CF; s_d.mode = s_q.mode;
                            end
                            CS_ERS_CF: begin
                                if (wr_data == CMD_BLK_CF) begin
                                    s_d.req[RQ_BLK] = 1'b1;
                                    s_d.addr = wr_addr;
                                    s_d.op   = OP_ERASE;
                                    s_d.blk  = 1'b1;
                                    s_d.mode = RM_STATUS;
                                end else if (wr_data == CMD_CHIP_CF && hit_a) begin
                                    s_d.req[RQ_CHIP] = 1'b1;
                                    s_d.op   = OP_ERASE;
                                    s_d.blk  = 1'b0;
                                    s_d.mode = RM_STATUS;
                                end
                            end
                            default: s_d.step = CS_IDLE;
                        endcase
                    end
                end
                OP_ERASE: begin
                    if (wr_data == CMD_RESET) begin
                        s_d.req[RQ_RD] = 1'b1;
                        s_d.op   = OP_NONE;
                        s_d.mode = RM_ARRAY;
                    end else if (wr_data == CMD_SUSPEND && s_q.blk) begin
                        s_d.req[RQ_SUSP] = 1'b1;
                        s_d.op   = OP_SUSP;
                        s_d.mode = RM_ARRAY;
                    end
                end
                OP_SUSP: begin
                    s_d.step = CS_IDLE;
                    case (s_q.step)
                        CS_IDLE: begin
                            if (wr_data == CMD_RESUME) begin
                                s_d.req[RQ_RES] = 1'b1;
                                s_d.op   = OP_ERASE;
                                s_d.mode = RM_STATUS;
                            end else if (wr_data == CMD_KEY_A && hit_a) begin
                                s_d.step = CS_UNL1;
                            end
                        end
                        CS_UNL1: if (wr_data == CMD_KEY_B && hit_b) s_d.step = CS_UNL2;
                        CS_UNL2: if (wr_data == CMD_PROG && hit_a) s_d.step = CS_PROG_ARM;
                        CS_PROG_ARM: begin
                            s_d.req[RQ_PROG] = 1'b1;
                            s_d.addr = wr_addr;
                            s_d.data = wr_data;
                            s_d.op   = OP_SUSP_PROG;
                            s_d.mode = RM_STATUS;
                        end
                        default: s_d.step = CS_IDLE;
                    endcase
                end
                default: ;   // program running: writes ignored
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.op   <= OP_NONE;
            s_q.step <= CS_IDLE;
            s_q.mode <= RM_ARRAY;
            s_q.blk  <= 1'b0;
            s_q.req  <= '0;
            s_q.addr <= '0;
            s_q.data <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_read_array = s_q.req[RQ_RD];
    assign req_auto_sel   = s_q.req[RQ_SIG];
    assign req_program    = s_q.req[RQ_PROG];
    assign req_blk_erase  = s_q.req[RQ_BLK];
    assign req_chip_erase = s_q.req[RQ_CHIP];
    assign req_suspend    = s_q.req[RQ_SUSP];
    assign req_resume     = s_q.req[RQ_RES];
    assign req_addr       = s_q.addr;
    assign req_data       = s_q.data;
    assign read_mode      = s_q.mode;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] MFR_CODE = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              ctl_done,
    input logic [1:0]        sig_addr,
    input logic              req_read_array,
    input logic              req_auto_sel,
    input logic              req_program,
    input logic              req_blk_erase,
    input logic              req_chip_erase,
    input logic              req_suspend,
    input logic              req_resume,
    input logic [1:0]        read_mode,
    input logic [DATA_W-1:0] sig_byte
);
    logic [6:0] reqs;
    logic erase_live, susp_live;
    assign reqs = {req_resume, req_suspend, req_chip_erase, req_blk_erase,
                   req_program, req_auto_sel, req_read_array};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_live <= 1'b0;
            susp_live  <= 1'b0;
        end else begin
            if (ctl_done || req_suspend || req_read_array) erase_live <= 1'b0;
            else if (req_blk_erase || req_resume)          erase_live <= 1'b1;
            if (req_resume)       susp_live <= 1'b0;
            else if (req_suspend) susp_live <= 1'b1;
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reqs)); // R12
    AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (reqs != 0) |-> $past(wr_en)); // R12
    AST_PROG_ONCE: assert property (@(posedge clk) disable iff (!rst_n) req_program |=> !req_program); // R11
    AST_PROG_STATUS: assert property (@(posedge clk) disable iff (!rst_n) req_program |-> read_mode == 2'd2); // R4
    AST_SIG_MODE: assert property (@(posedge clk) disable iff (!rst_n) req_auto_sel |-> read_mode == 2'd1); // R3
    AST_SIG_MFR: assert property (@(posedge clk) disable iff (!rst_n) (read_mode == 2'd1 && sig_addr == 2'b00) |-> sig_byte == MFR_CODE); // R3
    AST_RD_ARRAY: assert property (@(posedge clk) disable iff (!rst_n) req_read_array |-> read_mode == 2'd0); // R8
    AST_SUSP_LIVE: assert property (@(posedge clk) disable iff (!rst_n) req_suspend |-> erase_live); // R9
    AST_RESUME_SUSP: assert property (@(posedge clk) disable iff (!rst_n) req_resume |-> susp_live); // R10
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctl_done(ctl_done), .sig_addr(sig_addr),
    .req_read_array(req_read_array), .req_auto_sel(req_auto_sel), .req_program(req_program),
    .req_blk_erase(req_blk_erase), .req_chip_erase(req_chip_erase), .req_suspend(req_suspend),
    .req_resume(req_resume), .read_mode(read_mode), .sig_byte(sig_byte)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ctl_done = 1'b0;
    logic [1:0]  sig_addr = 2'b00;
    logic req_read_array, req_auto_sel, req_program, req_blk_erase;
    logic req_chip_erase, req_suspend, req_resume;
    logic [19:0] req_addr;
    logic [7:0]  req_data, sig_byte;
    logic [1:0]  read_mode;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int          kind;
        logic [19:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    flash_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_done(ctl_done), .sig_addr(sig_addr),
        .req_read_array(req_read_array), .req_auto_sel(req_auto_sel), .req_program(req_program),
        .req_blk_erase(req_blk_erase), .req_chip_erase(req_chip_erase), .req_suspend(req_suspend),
        .req_resume(req_resume), .req_addr(req_addr), .req_data(req_data),
        .read_mode(read_mode), .sig_byte(sig_byte)
    );

    // monitor: every request pulse is popped from the scoreboard and compared
    always @(negedge clk) begin
        logic [6:0] v;
        v = {req_resume, req_suspend, req_chip_erase, req_blk_erase,
             req_program, req_auto_sel, req_read_array};
        if (rst_n && v != 7'd0) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R12 unexpected request vector actual=%b expected=0000000", v);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (v != 7'(1 << e.kind)) begin
                    failures++;
                    $display("FAIL %s request vector actual=%b expected=%b", e.tag, v, 7'(1 << e.kind));
                end else if ((e.kind == 2 && (req_addr != e.addr || req_data != e.data)) ||
                             (e.kind == 3 && req_addr != e.addr)) begin
                    failures++;
                    $display("FAIL %s addr/data actual=%h/%h expected=%h/%h", e.tag, req_addr, req_data, e.addr, e.data);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [19:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock(input logic [19:0] hi);
        wr(hi | 20'h00555, 8'hAA);
        wr(hi | 20'h002AA, 8'h55);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        ctl_done = 1'b1;
        @(negedge clk);
        ctl_done = 1'b0;
    endtask

    task automatic chk_mode(input logic [1:0] exp, input string tag);
        checks++;
        if (read_mode !== exp) begin
            failures++;
            $display("FAIL %s read_mode actual=%0d expected=%0d", tag, read_mode, exp);
        end
    endtask

    task automatic chk_drained(input string tag);
        repeat (2) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL %s missing requests actual_pending=%0d expected=0", tag, q.size());
            q.delete();
        end
    endtask

    task automatic chk_sig(input logic [1:0] s, input logic [7:0] exp, input string tag);
        sig_addr = s;
        #1;
        checks++;
        if (sig_byte !== exp) begin
            failures++;
            $display("FAIL %s sig_byte actual=%h expected=%h", tag, sig_byte, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk_mode(2'd0, "R1");
        checks++;
        if ({req_resume, req_suspend, req_chip_erase, req_blk_erase, req_program, req_auto_sel, req_read_array} != 0) begin
            failures++;
            $display("FAIL R1 requests high in reset actual=1 expected=0");
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_mode(2'd0, "R1");

        // R2 R3: signature with high address bits set in unlock writes
        unlock(20'hFF800);
        push(1, 0, 0, "R3");
        wr(20'h7F555, 8'h90);
        chk_mode(2'd1, "R3");
        chk_drained("R2");
        chk_sig(2'b00, 8'h20, "R3");
        chk_sig(2'b01, 8'hD2, "R3");
        chk_sig(2'b10, 8'h00, "R3");

        // R7: bad second unlock byte aborts to array, no request
        wr(20'h00555, 8'hAA);
        wr(20'h002AA, 8'h56);
        wr(20'h00555, 8'h90);
        chk_drained("R7");
        chk_mode(2'd0, "R7");
        chk_sig(2'b00, 8'h00, "R3");

        // R8: plain reset and reset after unlock
        push(0, 0, 0, "R8");
        wr(20'h12345, 8'hF0);
        unlock(20'h0);
        push(0, 0, 0, "R8");
        wr(20'h00000, 8'hF0);
        chk_drained("R8");
        chk_mode(2'd0, "R8");

        // R9: suspend while idle has no effect
        wr(20'h00000, 8'hB0);
        chk_drained("R9");

        // R4: program
        unlock(20'h0);
        wr(20'h00555, 8'hA0);
        push(2, 20'h12345, 8'h5A, "R4");
        wr(20'h12345, 8'h5A);
        chk_mode(2'd2, "R4");
        // R11: signature instruction while programming is ignored
        unlock(20'h0);
        wr(20'h00555, 8'h90);
        chk_drained("R11");
        chk_mode(2'd2, "R11");
        done_pulse();

        // R7: wrong confirm in erase path aborts
        unlock(20'h0);
        wr(20'h00555, 8'h80);
        unlock(20'h0);
        wr(20'h00555, 8'h20);
        chk_drained("R7");
        chk_mode(2'd0, "R7");

        // R6: chip erase, suspend ignored during it
        unlock(20'h0);
        wr(20'h00555, 8'h80);
        unlock(20'h0);
        push(4, 0, 0, "R6");
        wr(20'h00555, 8'h10);
        chk_mode(2'd2, "R6");
        wr(20'h00000, 8'hB0);
        chk_drained("R9");
        chk_mode(2'd2, "R9");
        done_pulse();

        // R5: block erase
        unlock(20'h0);
        wr(20'h00555, 8'h80);
        unlock(20'h0);
        push(3, 20'h40123, 0, "R5");
        wr(20'h40123, 8'h30);
        chk_mode(2'd2, "R5");
        // R11: other command during erase ignored
        wr(20'h00555, 8'hAA);
        chk_drained("R11");
        chk_mode(2'd2, "R11");
        // R9: suspend
        push(5, 0, 0, "R9");
        wr(20'h0ABCD, 8'hB0);
        chk_mode(2'd0, "R9");
        // R10: stray write ignored, then program inside suspend
        wr(20'h00000, 8'hF0);
        chk_drained("R10");
        chk_mode(2'd0, "R10");
        unlock(20'h0);
        wr(20'h00555, 8'hA0);
        push(2, 20'h00777, 8'h3C, "R10");
        wr(20'h00777, 8'h3C);
        chk_mode(2'd2, "R10");
        done_pulse();
        // R11: done returns to suspended, so resume is accepted
        push(6, 0, 0, "R11");
        wr(20'h55555, 8'h30);
        chk_mode(2'd2, "R10");
        // R8: reset ends the resumed erase
        push(0, 0, 0, "R8");
        wr(20'h00000, 8'hF0);
        chk_mode(2'd0, "R8");
        wr(20'h00000, 8'hB0);
        chk_drained("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule